// File: doc/BRIEF.md
# Gyro Head Comb-Wave Signal Generator

This block stands in for the detector of a closed-loop fiber-optic gyro head, so that a modulation/demodulation circuit can be tested without optics. It holds a pseudo-random rate word X, which plays the part of the optical path difference. It drives a 16-bit DAC with a comb wave of fixed period. The period has an odd half and an even half. The two half levels sit symmetrically about a bias, and they differ by the amount of X minus the feedback step that the circuit under test currently applies.

The circuit under test extracts its feedback step F and presents it to the block every cycle. When F matches X the comb flattens to the bias level, which shows that the loop has closed on the injected rate. X advances on a fixed number of full periods or on an explicit request, which gives the loop a fresh rate to chase. While the enable is low, the generator sits idle at the bias level and keeps reloading its seed.

Top module: `gyro_comb_gen`

## Requirements
- R1: After reset, `dac_o` equals BIAS, `dac_wr_o` and `odd_o` are 0, and `x_o` is 16'hACE1.
- R2: While `en_i` is low, `x_o` takes `seed_i` on each clock (a zero seed is replaced by 16'h0001), `dac_o` holds BIAS, `dac_wr_o` and `odd_o` are 0, and the half-period timing restarts.
- R3: One X step replaces state s with (s >> 1) XOR (s[0] ? 16'hB400 : 0), which is a maximal-length sequence that never reaches zero.
- R4: Each half period lasts HALF_LEN enabled clocks, and `odd_o` alternates between halves. The first half after enabling is odd (`odd_o`=1).
- R5: In an odd half, the DAC word is BIAS + floor((X − F)/2), with X and F read as signed two's-complement 16-bit values.
- R6: In an even half, the DAC word is BIAS − floor((X − F)/2).
- R7: The DAC word saturates at 0 and at 65535 rather than wrapping.
- R8: X steps once at the end of every UPD_PERIODS-th full period, and a full period ends at the last cycle of an even half.
- R9: `adv_req_i` high on an enabled clock steps X once. When it coincides with a scheduled step, X still steps only once.
- R10: `dac_o`, `odd_o` and `dac_wr_o` are registered. The word seen after a clock reflects the X, F and parity from before that clock, and `dac_wr_o` is 1 on every cycle that follows an enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; when low, the block idles and reloads the seed |
| seed_i | input | 16 | Rate-generator seed |
| adv_req_i | input | 1 | Request to step X |
| fb_i | input | 16 | Signed feedback step from the circuit under test |
| dac_o | output | 16 | DAC word |
| dac_wr_o | output | 1 | DAC write strobe, one per fresh word |
| odd_o | output | 1 | Parity of the half that `dac_o` belongs to (1 = odd) |
| x_o | output | 16 | Current rate word X |

## Verification
The bench drives feedback values at both signed extremes, so the half-difference saturates at the top of the range in one instance (BIAS 40000) and at the bottom in another (BIAS 24000). A design that wrapped instead of clamping would output a word near the opposite rail. A zero seed is applied to show that the generator is never trapped at zero. A design that let a zero seed through would hold X stuck at 0. Requests that fall on or near a scheduled step check that the two never produce a double step, which would show up as X skipping a sequence value. Toggling the enable mid-half checks that timing restarts on an odd half, and a design that failed to restart would emit the wrong sign of the level difference.

// File: rtl/gcg_pkg.sv
package gcg_pkg;
  localparam int unsigned DW = 16;
  localparam logic [DW-1:0] RST_STATE = 16'hACE1;
  localparam logic [DW-1:0] TAP_MASK  = 16'hB400;
  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/gcg_lfsr.sv
module gcg_lfsr
  import gcg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  word_t seed_i,
  input  logic  step_i,
  output word_t state_o
);
  word_t q;
  word_t nxt;

  assign nxt = (q >> 1) ^ (q[0] ? TAP_MASK : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= RST_STATE;
    else if (!en_i)     q <= (seed_i == '0) ? word_t'(1) : seed_i;
    else if (step_i)    q <= nxt;
  end

  assign state_o = q;

  a_r3_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni) q != '0);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> $stable(q));
endmodule

// File: rtl/gcg_timer.sv
module gcg_timer #(
  parameter int unsigned HALF_LEN    = 800,
  parameter int unsigned UPD_PERIODS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic odd_o,
  output logic upd_o
);
  localparam int unsigned CW    = (HALF_LEN > 1) ? $clog2(HALF_LEN) : 1;
  localparam int unsigned PW    = (UPD_PERIODS > 1) ? $clog2(UPD_PERIODS) : 1;
  localparam logic [CW-1:0] CLAST = CW'(HALF_LEN - 1);
  localparam logic [PW-1:0] PLAST = PW'(UPD_PERIODS - 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] per_q;
  logic          odd_q;
  logic          half_end;
  logic          per_end;

  assign half_end = (cnt_q == CLAST);
  assign per_end  = half_end && !odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      odd_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      per_q <= '0;
      odd_q <= 1'b1;
    end else if (half_end) begin
      cnt_q <= '0;
      odd_q <= ~odd_q;
      if (per_end) per_q <= (per_q == PLAST) ? '0 : per_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign odd_o = odd_q;
  assign upd_o = en_i && per_end && (per_q == PLAST);

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CLAST);
  a_r4_parity_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !half_end) |=> (odd_q == $past(odd_q)));
  a_r8_upd_even_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> odd_q);
endmodule

// File: rtl/gcg_level.sv
module gcg_level
  import gcg_pkg::*;
#(
  parameter int unsigned BIAS = 32768
) (
  input  logic  odd_i,
  input  word_t x_i,
  input  word_t f_i,
  output word_t lvl_o
);
  localparam int unsigned LW = DW + 3;
  localparam logic signed [LW-1:0] BIAS_S = LW'(BIAS);
  localparam logic signed [LW-1:0] MAX_S  = LW'((1 << DW) - 1);

  logic signed [DW:0]   diff;
  logic signed [DW:0]   half;
  logic signed [LW-1:0] half_x;
  logic signed [LW-1:0] sum;

  always_comb begin
    diff   = $signed({x_i[DW-1], x_i}) - $signed({f_i[DW-1], f_i});
    half   = diff >>> 1;
    half_x = LW'(half);
    sum    = odd_i ? (BIAS_S + half_x) : (BIAS_S - half_x);
    if (sum < 0)          lvl_o = '0;
    else if (sum > MAX_S) lvl_o = '1;
    else                  lvl_o = sum[DW-1:0];
  end

  always_comb begin
    if (odd_i && !diff[DW] && BIAS < (1 << DW))
      a_r5_odd_not_below: assert (lvl_o >= word_t'(BIAS));
    if (!odd_i && !diff[DW] && BIAS < (1 << DW))
      a_r6_even_not_above: assert (lvl_o <= word_t'(BIAS));
  end
endmodule

// File: rtl/gyro_comb_gen.sv
module gyro_comb_gen
  import gcg_pkg::*;
#(
  parameter int unsigned HALF_LEN    = 16 * 50,
  parameter int unsigned UPD_PERIODS = 4,
  parameter int unsigned BIAS        = 32768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [15:0] seed_i,
  input  logic        adv_req_i,
  input  logic [15:0] fb_i,
  output logic [15:0] dac_o,
  output logic        dac_wr_o,
  output logic        odd_o,
  output logic [15:0] x_o
);
  localparam word_t BIAS_W = word_t'(BIAS);

  word_t x;
  word_t lvl;
  logic  odd;
  logic  upd;
  word_t dac_q;
  logic  wr_q;
  logic  odd_q;

  gcg_timer #(.HALF_LEN(HALF_LEN), .UPD_PERIODS(UPD_PERIODS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .odd_o (odd),
    .upd_o (upd)
  );

  gcg_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .seed_i (seed_i),
    .step_i (upd || adv_req_i),
    .state_o(x)
  );

  gcg_level #(.BIAS(BIAS)) u_level (
    .odd_i(odd),
    .x_i  (x),
    .f_i  (fb_i),
    .lvl_o(lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q <= BIAS_W;
      wr_q  <= 1'b0;
      odd_q <= 1'b0;
    end else if (en_i) begin
      dac_q <= lvl;
      wr_q  <= 1'b1;
      odd_q <= odd;
    end else begin
      dac_q <= BIAS_W;
      wr_q  <= 1'b0;
      odd_q <= 1'b0;
    end
  end

  assign dac_o    = dac_q;
  assign dac_wr_o = wr_q;
  assign odd_o    = odd_q;
  assign x_o      = x;

  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (dac_o == BIAS_W && !dac_wr_o && !odd_o));
  a_r10_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> dac_wr_o);
  a_r9_req_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_req_i) |=> (x_o != $past(x_o)));
  a_r4_first_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dac_wr_o) |=> odd_o);
endmodule

// File: tb/sim_gyro_comb_gen.sv
`timescale 1ns/1ps
module sim_gyro_comb_gen;
  localparam int HL  = 12;
  localparam int UP  = 3;
  localparam int BHI = 40000;
  localparam int BLO = 24000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic [15:0] seed = 16'h1234;
  logic        adv = 0;
  logic [15:0] fb = 0;
  logic [15:0] dac0, dac1, x0, x1;
  logic        wr0, wr1, odd0, odd1;

  int checks = 0;
  int fails = 0;
  int sat_hi = 0, sat_lo = 0, n_upd = 0, n_adv = 0, n_both = 0;

  always #2 clk = ~clk;

  gyro_comb_gen #(.HALF_LEN(HL), .UPD_PERIODS(UP), .BIAS(BHI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .seed_i(seed), .adv_req_i(adv),
    .fb_i(fb), .dac_o(dac0), .dac_wr_o(wr0), .odd_o(odd0), .x_o(x0));
  gyro_comb_gen #(.HALF_LEN(HL), .UPD_PERIODS(UP), .BIAS(BLO)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .seed_i(seed), .adv_req_i(adv),
    .fb_i(fb), .dac_o(dac1), .dac_wr_o(wr1), .odd_o(odd1), .x_o(x1));

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic int level(input int bias, input bit odd,
                               input logic [15:0] x, input logic [15:0] f);
    int d, h, v;
    d = int'($signed(x)) - int'($signed(f));
    h = d >>> 1;
    v = odd ? bias + h : bias - h;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return v;
  endfunction

  // reference model
  logic [15:0] m_x = 16'hACE1;
  int          m_cnt = 0, m_per = 0;
  bit          m_odd = 1;
  int          m_dac0 = BHI, m_dac1 = BLO;
  bit          m_wr = 0, m_oddo = 0, m_sat0 = 0, m_sat1 = 0;
  string       m_xtag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_x <= 16'hACE1; m_cnt <= 0; m_per <= 0; m_odd <= 1;
      m_dac0 <= BHI; m_dac1 <= BLO; m_wr <= 0; m_oddo <= 0; m_xtag <= "R1";
    end else if (!en) begin
      m_x <= (seed == 0) ? 16'h0001 : seed;
      m_cnt <= 0; m_per <= 0; m_odd <= 1;
      m_dac0 <= BHI; m_dac1 <= BLO; m_wr <= 0; m_oddo <= 0; m_xtag <= "R2";
    end else begin
      automatic bit upd = (m_cnt == HL-1) && !m_odd && (m_per == UP-1);
      m_dac0 <= level(BHI, m_odd, m_x, fb);
      m_dac1 <= level(BLO, m_odd, m_x, fb);
      m_sat0 <= (level(BHI, m_odd, m_x, fb) == 65535);
      m_sat1 <= (level(BLO, m_odd, m_x, fb) == 0);
      m_wr <= 1; m_oddo <= m_odd;
      if (upd || adv) begin
        m_x <= lfsr_step(m_x);
        m_xtag <= adv ? "R9" : "R8";
        if (upd) n_upd++;
        if (adv) n_adv++;
        if (upd && adv) n_both++;
      end else m_xtag <= "R3";
      if (m_cnt == HL-1) begin
        m_cnt <= 0; m_odd <= !m_odd;
        if (!m_odd) m_per <= (m_per == UP-1) ? 0 : m_per + 1;
      end else m_cnt <= m_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string t0, t1;
      t0 = !m_wr ? "R2" : m_sat0 ? "R7" : m_oddo ? "R5" : "R6";
      t1 = !m_wr ? "R2" : m_sat1 ? "R7" : m_oddo ? "R5" : "R6";
      chk(t0, dac0, m_dac0);
      chk(t1, dac1, m_dac1);
      chk(m_xtag, x0, m_x);
      chk("R4", odd0, m_oddo);
      chk("R10", wr0, m_wr);
      if (m_wr && m_sat0) sat_hi++;
      if (m_wr && m_sat1) sat_lo++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_rand(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      adv = ($urandom % 16) == 0;
      case (mode)
        0: fb = 16'($urandom);
        1: fb = ($urandom % 2) ? 16'h8000 : 16'h7FFF;
        default: fb = x0;  // loop closed: comb flattens to bias
      endcase
    end
    @(negedge clk);
    adv = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    #7;
    // R1 reset state
    chk("R1", dac0, BHI);
    chk("R1", wr0, 0);
    chk("R1", odd0, 0);
    chk("R1", x0, 16'hACE1);
    @(negedge clk);
    rst_n = 1;
    // R2 zero seed is replaced
    seed = 16'h0000;
    cyc(2);
    chk("R2", x0, 16'h0001);
    seed = 16'h1234;
    cyc(1);
    chk("R2", x0, 16'h1234);
    // R4 first half odd, parity length
    en = 1;
    cyc(1);
    chk("R4", odd0, 1);
    cyc(HL);
    chk("R4", odd0, 0);
    cyc(HL);
    chk("R4", odd0, 1);
    // R10 word follows fb one clock later
    fb = x0;
    cyc(1);
    chk("R10", dac0, BHI);
    run_rand(600, 0);
    // R2 idle mid-half, then restart
    en = 0;
    cyc(3);
    chk("R2", dac0, BHI);
    chk("R2", wr0, 0);
    chk("R2", x0, 16'h1234);
    seed = 16'hBEEF;
    en = 1;
    run_rand(3000, 1);
    run_rand(300, 2);
    run_rand(2000, 0);
    // R9 request alone steps once
    begin
      logic [15:0] xb;
      xb = x0;
      adv = 1;
      cyc(1);
      adv = 0;
      chk("R9", x0, lfsr_step(xb));
    end
    run_rand(3000, 1);
    en = 0;
    cyc(2);
    chk("R7", (sat_hi > 0) ? 1 : 0, 1);
    chk("R7", (sat_lo > 0) ? 1 : 0, 1);
    chk("R8", (n_upd > 0) ? 1 : 0, 1);
    chk("R9", (n_adv > 0) ? 1 : 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule